// File: doc/BRIEF.md
# Bit-Order Selectable Serial Shifter

This block moves one byte at a time over a synchronous serial link, sending and receiving at the same time. Software loads a data register, sets the bit order and the shift-clock source in a control register, and sets the start bit. Eight shift-clock periods later the byte that came in on the serial input has replaced the byte that went out, the start bit reads back clear, and a completion flag is raised for the interrupt logic.

The shift clock comes either from an internal divider or from an external pin. The internal divider runs at 2, 8 or 32 instruction cycles per shift-clock period, where one instruction cycle is four system clocks. With an internal clock the block drives its clock pin, which rests high between transfers. With the external clock the pin is an input, and it passes through a two-flop synchronizer before its edges are detected. Outgoing data changes on falling shift-clock edges, and incoming data is sampled on rising edges.

Top module: `serial_byte_shifter`

## Requirements
- R1: After reset, busy and irq_flag are 0, data_out is 0, sdo and sck_out are 1, and sck_oe is 1, because clock select resets to code 0.
- R2: A data write (data_wr high) while idle loads data_in into data_out at the next clock edge. A data write while busy is high leaves data_out unchanged.
- R3: A control write with ctrl_start high while idle sets busy at the next edge. A control write while busy is ignored, including its bit order and clock select.
- R4: Clock select codes 0, 1 and 2 give internal shift-clock half-periods of 4, 16 and 64 clocks. The first falling edge of sck_out comes at the edge that is one half-period after the edge that set busy.
- R5: sck_out is high whenever busy is low. sck_oe is 1 for clock select codes 0 to 2 and 0 for code 3.
- R6: With ctrl_msb_first = 0, the j-th falling shift-clock edge (j = 0..7) puts bit j of the loaded byte on sdo. sdo changes at no other time.
- R7: With ctrl_msb_first = 1, the j-th falling shift-clock edge puts bit 7-j of the loaded byte on sdo.
- R8: sdi is sampled on each rising shift-clock edge. The j-th sample lands at bit j (LSB first) or at bit 7-j (MSB first) of the byte that data_out shows once the transfer completes.
- R9: At the edge carrying the eighth rising shift-clock edge, busy clears and irq_flag sets. irq_flag stays set until an irq_clr pulse, and a completion in the same cycle wins over the clear.
- R10: With clock select code 3, sck_in passes through two synchronizer flops. A change on sck_in takes effect at the third clock edge after it, and sck_out does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_in | input | 8 | Byte to load into the data register |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_msb_first | input | 1 | Bit order: 1 sends the MSB first, 0 sends the LSB first |
| ctrl_clk_sel | input | 2 | Shift-clock source: 0/1/2 internal at 2/8/32 instruction cycles, 3 external |
| ctrl_start | input | 1 | Begins a transfer when written as 1 while idle |
| irq_clr | input | 1 | Clears the completion flag |
| data_out | output | 8 | Data register contents |
| busy | output | 1 | Start bit read-back, high during a transfer |
| irq_flag | output | 1 | Completion flag |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock output |
| sck_oe | output | 1 | High when the block drives the shift-clock pin |

## Verification
Register writes take effect at the first clock edge after the strobe. With an internal clock the first sdo update is due a full half-period of edges later, and each later sdo update or sdi sample follows after one more half-period. On the external path every result comes three edges after the sck_in change that caused it, because of the two synchronizer flops and the edge-detect flop. The bench drives inputs and samples outputs on falling clock edges. A behavioural reference model counts elapsed cycles and synchronizer delay in the same units and advances on each rising edge, so every output is compared with its expected value in the cycle where it is due. Explicit checks measure the half-period latency and the effect of ignored writes.

// File: rtl/sio_pkg.sv
// Package: shared types for the serial shifter.
// Assumes: clock-select codes are fixed by the control register layout.
package sio_pkg;
    typedef enum logic [1:0] {
        SCK_FAST = 2'd0,
        SCK_MID  = 2'd1,
        SCK_SLOW = 2'd2,
        SCK_EXT  = 2'd3
    } sck_sel_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } sck_ev_t;
endpackage

// File: rtl/sio_sck_gen.sv
// Module: shift-clock source. Produces one-cycle fall/rise events either from
// an internal half-period divider or from a synchronized external clock pin.
// Assumes: sel is stable while busy; sck_in is asynchronous to clk.
module sio_sck_gen
    import sio_pkg::*;
#(
    parameter int INST_DIV    = 4,
    parameter int RATE_FAST   = 2,
    parameter int RATE_MID    = 8,
    parameter int RATE_SLOW   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy,
    input  sck_sel_e sel,
    input  logic     sck_in,
    output sck_ev_t  ev,
    output logic     sck_out,
    output logic     sck_oe
);
    localparam int HALF_FAST = RATE_FAST * INST_DIV / 2;
    localparam int HALF_MID  = RATE_MID * INST_DIV / 2;
    localparam int HALF_SLOW = RATE_SLOW * INST_DIV / 2;
    localparam int CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

    logic [CNT_W-1:0]     div_q;
    logic [CNT_W-1:0]     half_m1;
    logic                 sck_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 internal;
    logic                 tick;
    logic                 ext_fall;
    logic                 ext_rise;

    // Pick the terminal count for the selected internal rate.
    always_comb begin
        case (sel)
            SCK_FAST: half_m1 = CNT_W'(HALF_FAST - 1);
            SCK_MID:  half_m1 = CNT_W'(HALF_MID - 1);
            default:  half_m1 = CNT_W'(HALF_SLOW - 1);
        endcase
    end

    assign internal = (sel != SCK_EXT);
    assign tick     = busy && internal && (div_q == half_m1);

    // Half-period divider, held at zero outside an internal transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || !internal) div_q <= '0;
        else if (tick)                    div_q <= '0;
        else                              div_q <= div_q + 1'b1;
    end

    // Internal shift clock, idling high and toggling on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    sck_q <= 1'b1;
        else if (tick) sck_q <= ~sck_q;
    end

    // Synchronizer stages plus one edge-detect stage for the external clock.
    for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage captures the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= sck_in;
            end
        end else begin : g_next
            // Later stages shift the sampled value along.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign ext_fall = busy && !internal && sync_q[SYNC_STAGES] && !sync_q[SYNC_STAGES-1];
    assign ext_rise = busy && !internal && !sync_q[SYNC_STAGES] && sync_q[SYNC_STAGES-1];

    assign ev.fall = (tick && sck_q) || ext_fall;
    assign ev.rise = (tick && !sck_q) || ext_rise;
    assign sck_out = sck_q;
    assign sck_oe  = internal;

    // R5: the driven clock rests high whenever no transfer runs.
    p_sck_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    // R10: the external source never moves the driven clock.
    p_ext_clock_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SCK_EXT) |-> $stable(sck_out));
endmodule

// File: rtl/sio_shift_core.sv
// Module: shift register, bit counter and serial output flop. Shifts out on
// fall events, samples sdi on rise events, and flags the final rise.
// Assumes: load and shift events never coincide (load only when idle).
module sio_shift_core
    import sio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_byte,
    input  logic             msb_first,
    input  sck_ev_t          ev,
    input  logic             sdi,
    output logic             sdo,
    output logic             last,
    output logic [WIDTH-1:0] rx_next
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sdo_q;

    // Next shift value: sdi enters at the end opposite the outgoing bit.
    always_comb begin
        if (msb_first) rx_next = {sr_q[WIDTH-2:0], sdi};
        else           rx_next = {sdi, sr_q[WIDTH-1:1]};
    end

    // Shift register: loaded at start, shifted on every rise event.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (load)    sr_q <= load_byte;
        else if (ev.rise) sr_q <= rx_next;
    end

    // Count of sampled bits within the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= '0;
        else if (ev.rise) cnt_q <= cnt_q + 1'b1;
    end

    // Output flop: presents the next outgoing bit on each fall event.
    always_ff @(posedge clk) begin
        if (!rst_n)       sdo_q <= 1'b1;
        else if (ev.fall) sdo_q <= msb_first ? sr_q[WIDTH-1] : sr_q[0];
    end

    assign last = ev.rise && (cnt_q == CNT_W'(WIDTH - 1));
    assign sdo  = sdo_q;

    // R6: serial output moves only right after a fall event.
    p_sdo_on_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev.fall) |-> $stable(sdo));

    // R8: sampling and shifting never happen in the same cycle as a load.
    p_no_shift_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !ev.rise);
endmodule

// File: rtl/serial_byte_shifter.sv
// Module: top of the byte-wide synchronous serial shifter. Holds the data and
// control registers, the busy (start) bit and the completion flag.
// Assumes: writes arrive as single-cycle strobes; sdi is stable around the
// rising shift-clock edge.
module serial_byte_shifter
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int INST_DIV    = 4,
    parameter int RATE_FAST   = 2,
    parameter int RATE_MID    = 8,
    parameter int RATE_SLOW   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_msb_first,
    input  logic [1:0]        ctrl_clk_sel,
    input  logic              ctrl_start,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    output logic              irq_flag,
    input  logic              sdi,
    output logic              sdo,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe
);
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rx_next;
    logic              busy_q;
    logic              irq_q;
    logic              msb_q;
    sck_sel_e          sel_q;
    logic              start_req;
    logic              last_ev;
    sck_ev_t           ev;

    assign start_req = ctrl_wr && ctrl_start && !busy_q;

    // Start bit: set by a start write, cleared after the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (start_req) busy_q <= 1'b1;
        else if (last_ev)   busy_q <= 1'b0;
    end

    // Mode fields, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
            sel_q <= SCK_FAST;
        end else if (ctrl_wr && !busy_q) begin
            msb_q <= ctrl_msb_first;
            sel_q <= sck_sel_e'(ctrl_clk_sel);
        end
    end

    // Data register: software load while idle, received byte at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                  data_q <= '0;
        else if (last_ev)            data_q <= rx_next;
        else if (data_wr && !busy_q) data_q <= data_in;
    end

    // Completion flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (last_ev) irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    sio_sck_gen #(
        .INST_DIV    (INST_DIV),
        .RATE_FAST   (RATE_FAST),
        .RATE_MID    (RATE_MID),
        .RATE_SLOW   (RATE_SLOW),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy_q),
        .sel     (sel_q),
        .sck_in  (sck_in),
        .ev      (ev),
        .sck_out (sck_out),
        .sck_oe  (sck_oe)
    );

    sio_shift_core #(
        .WIDTH (DATA_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_req),
        .load_byte (data_q),
        .msb_first (msb_q),
        .ev        (ev),
        .sdi       (sdi),
        .sdo       (sdo),
        .last      (last_ev),
        .rx_next   (rx_next)
    );

    assign data_out = data_q;
    assign busy     = busy_q;
    assign irq_flag = irq_q;

    // R3: a transfer begins only from a start write.
    p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(ctrl_wr && ctrl_start));

    // R9: completion raises the flag in the same edge that clears busy.
    p_flag_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> irq_q);

    // R2: the data register is frozen throughout a transfer.
    p_data_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_q) && busy_q) |-> $stable(data_q));
endmodule

// File: tb/sim_serial_byte_shifter.sv
module sim_serial_byte_shifter;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       ctrl_wr = 1'b0;
    logic       ctrl_msb_first = 1'b0;
    logic [1:0] ctrl_clk_sel = '0;
    logic       ctrl_start = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] data_out;
    logic       busy, irq_flag, sdo, sck_out, sck_oe;
    logic       sdi = 1'b0;
    logic       sck_in = 1'b1;

    serial_byte_shifter u0 (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_msb_first(ctrl_msb_first),
        .ctrl_clk_sel(ctrl_clk_sel), .ctrl_start(ctrl_start),
        .irq_clr(irq_clr), .data_out(data_out), .busy(busy),
        .irq_flag(irq_flag), .sdi(sdi), .sdo(sdo), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model state: elapsed-cycle counting, not a divider copy.
    int m_busy, m_sck, m_sdo, m_irq, m_msb, m_sel, m_t, m_bit;
    int h1, h2, h3;
    logic [7:0] m_data, m_tx, m_rx;
    int b0, e_fall, e_rise, half, idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_sck = 1; m_sdo = 1; m_irq = 0; m_msb = 0; m_sel = 0;
            m_t = 0; m_bit = 0; m_data = '0; m_tx = '0; m_rx = '0;
            h1 = 1; h2 = 1; h3 = 1;
        end else begin
            b0 = m_busy; e_fall = 0; e_rise = 0;
            half = (m_sel == 0) ? 4 : (m_sel == 1) ? 16 : 64;
            if (b0 != 0) begin
                if (m_sel == 3) begin
                    e_fall = (h3 == 1 && h2 == 0) ? 1 : 0;
                    e_rise = (h3 == 0 && h2 == 1) ? 1 : 0;
                end else begin
                    m_t++;
                    if (m_t % half == 0) begin
                        if (m_sck != 0) e_fall = 1; else e_rise = 1;
                        m_sck = (m_sck != 0) ? 0 : 1;
                    end
                end
            end
            h3 = h2; h2 = h1; h1 = int'(sck_in);
            idx = (m_msb != 0) ? 7 - m_bit : m_bit;
            if (e_fall != 0) m_sdo = int'(m_tx[idx]);
            if (irq_clr) m_irq = 0;
            if (e_rise != 0) begin
                m_rx[idx] = sdi;
                m_bit++;
                if (m_bit == 8) begin
                    m_busy = 0; m_irq = 1; m_data = m_rx;
                end
            end
            if (b0 == 0 && ctrl_wr) begin
                m_msb = int'(ctrl_msb_first);
                m_sel = int'(ctrl_clk_sel);
                if (ctrl_start) begin
                    m_busy = 1; m_t = 0; m_bit = 0; m_tx = m_data;
                end
            end
            if (b0 == 0 && data_wr) m_data = data_in;
        end
    end

    // Serial input pattern: a small LFSR stepped each falling edge.
    logic [7:0] lfsr = 8'h5B;
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        sdi  <= lfsr[7];
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 busy", int'(busy), m_busy);
            chk("R9 irq_flag", int'(irq_flag), m_irq);
            chk("R4 sck_out", int'(sck_out), m_sck);
            chk("R5 sck_oe", int'(sck_oe), (m_sel != 3) ? 1 : 0);
            chk("R8 data_out", int'(data_out), int'(m_data));
            if (m_msb != 0) chk("R7 sdo", int'(sdo), m_sdo);
            else            chk("R6 sdo", int'(sdo), m_sdo);
        end
    end

    task automatic start_xfer(input logic [7:0] d, input logic msb, input logic [1:0] sel);
        data_wr = 1'b1; data_in = d;
        @(negedge clk);
        data_wr = 1'b0;
        ctrl_wr = 1'b1; ctrl_msb_first = msb; ctrl_clk_sel = sel; ctrl_start = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 flag cleared", int'(irq_flag), 0);
    endtask

    // Internal-clock transfer with first-fall latency measurement.
    task automatic run_int(input logic [7:0] d, input logic msb, input logic [1:0] sel, input int hp);
        int c;
        start_xfer(d, msb, sel);
        c = 1;
        while (sck_out && c < 200) begin
            @(negedge clk);
            c++;
        end
        chk("R4 first fall latency", c, hp + 1);
        wait_idle();
        chk("R9 done flag", int'(irq_flag), 1);
        chk("R3 busy cleared", int'(busy), 0);
        clear_flag();
    endtask

    initial begin
        logic [7:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq_flag", int'(irq_flag), 0);
        chk("R1 data_out", int'(data_out), 0);
        chk("R1 sdo", int'(sdo), 1);
        chk("R1 sck_out", int'(sck_out), 1);
        chk("R1 sck_oe", int'(sck_oe), 1);

        // Fast rate, LSB first, with ignored writes mid-transfer.
        start_xfer(8'hA5, 1'b0, 2'd0);
        repeat (6) @(negedge clk);
        held = data_out;
        data_wr = 1'b1; data_in = 8'h3C;
        @(negedge clk);
        data_wr = 1'b0;
        chk("R2 write while busy", int'(data_out), int'(held));
        ctrl_wr = 1'b1; ctrl_clk_sel = 2'd3; ctrl_msb_first = 1'b1; ctrl_start = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_start = 1'b0;
        chk("R3 ctrl write while busy", int'(sck_oe), 1);
        wait_idle();
        chk("R9 done flag", int'(irq_flag), 1);
        clear_flag();

        // Idle data write.
        data_wr = 1'b1; data_in = 8'h71;
        @(negedge clk);
        data_wr = 1'b0;
        chk("R2 idle write", int'(data_out), 8'h71);

        run_int(8'hA5, 1'b0, 2'd0, 4);
        run_int(8'h96, 1'b1, 2'd1, 16);
        run_int(8'h01, 1'b0, 2'd2, 64);
        run_int(8'h80, 1'b1, 2'd0, 4);

        // External clock, MSB first.
        start_xfer(8'hC3, 1'b1, 2'd3);
        chk("R10 sck_oe external", int'(sck_oe), 0);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            repeat (6) @(negedge clk);
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        wait_idle();
        chk("R10 external done", int'(irq_flag), 1);
        chk("R10 sck_out quiet", int'(sck_out), 1);
        clear_flag();

        // External clock, LSB first.
        start_xfer(8'h3A, 1'b0, 2'd3);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            repeat (5) @(negedge clk);
            sck_in = 1'b1;
            repeat (5) @(negedge clk);
        end
        wait_idle();
        chk("R10 external lsb done", int'(busy), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule